// File: doc/BRIEF.md
# Lane Compaction Unit

This block accepts one beat of LANES data lanes per handshake, each lane tagged with a keep flag. It moves every flagged element down into the lowest-numbered output lanes and keeps the elements in their original order. Alongside the packed vector it reports how many lanes were flagged. The contents of output lanes at or above that count carry no meaning.

The target lane of each kept element is the number of flagged lanes below it, which is an exclusive prefix sum of the flags. The sum is formed by a log2(LANES)-step parallel scan in which every lane adds in a neighbour at doubling distance. This scan has fewer steps than a work-efficient two-sweep scan, but it uses more adders. Each scan step is registered. A final registered crossbar stage places the data and emits the count.

Both sides use a valid/ready handshake. A single stall signal freezes the whole pipeline while the output is held.

Top module: `lane_packer`

## Requirements
- R1: For an accepted beat with Q flagged lanes, output lanes 0 to Q-1 hold the flagged input elements in increasing input-lane order. Lane j of the vector is bits [j*DATA_W +: DATA_W]. Flag bit i belongs to lane i.
- R2: out_count equals the number of set bits in the accepted in_flags, and its value lies between 0 and LANES.
- R3: A flagged element in input lane i goes to the output lane whose index equals the number of set flags in lanes 0 to i-1. For example, with flags set only at lanes 0 and 3, lane 0 stays at lane 0 and lane 3 moves to lane 1.
- R4: While out_ready is held high, a beat accepted at one clock edge is presented with out_valid exactly log2(LANES)+1 cycles later. One beat per cycle is accepted and delivered.
- R5: When no flag is set, out_count is 0.
- R6: When every flag is set, out_data equals in_data and out_count equals LANES.
- R7: While out_valid is high and out_ready is low, in_ready is low and out_valid, out_data and out_count hold their values. No beat is lost or duplicated.
- R8: After reset, out_valid is low and in_ready is high.
- R9: A cycle with in_valid low produces no output beat, whatever in_flags and in_data hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat accepted at this edge when in_valid is high |
| in_flags | input | LANES | Keep flag per lane, bit i for lane i |
| in_data | input | LANES*DATA_W | Input lanes, lane i at bits [i*DATA_W +: DATA_W] |
| out_valid | output | 1 | Packed beat present |
| out_ready | input | 1 | Downstream takes the packed beat |
| out_data | output | LANES*DATA_W | Packed lanes; only lanes below out_count are defined |
| out_count | output | $clog2(LANES)+1 | Number of flagged lanes in the beat |

## Verification
A packed beat is due log2(LANES)+1 cycles after its acceptance edge, which is 6 cycles at the default of 32 lanes, and the count arrives in the same cycle as the data. The bench stamps each accepted beat with its cycle number. In phases where out_ready never drops, it requires the delivery cycle to differ from that stamp by exactly this latency. In phases with backpressure, it checks only order and content, and during a stall it compares the held output one cycle later. All samples are taken one time unit after the falling edge, when the handshake state for the next rising edge is settled.

// File: rtl/lane_pack_pkg.sv
package lane_pack_pkg;

    localparam int unsigned LP_DEF_LANES  = 32;
    localparam int unsigned LP_DEF_DATA_W = 16;

    // neighbour distance used by scan step k
    function automatic int unsigned scan_dist(input int unsigned stage);
        return 32'd1 << stage;
    endfunction

    // bits needed to hold a count from 0 to lanes
    function automatic int unsigned count_width(input int unsigned lanes);
        return $clog2(lanes) + 1;
    endfunction

endpackage

// File: rtl/lane_pack_scan_step.sv
module lane_pack_scan_step #(
    parameter int LANES  = 32,
    parameter int DATA_W = 16,
    parameter int CW     = 6,
    parameter int DIST   = 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    i_vld,
    input  logic [LANES-1:0]        i_flag,
    input  logic [LANES*DATA_W-1:0] i_data,
    input  logic [LANES*CW-1:0]     i_sum,
    output logic                    o_vld,
    output logic [LANES-1:0]        o_flag,
    output logic [LANES*DATA_W-1:0] o_data,
    output logic [LANES*CW-1:0]     o_sum
);

    logic [LANES*CW-1:0] sum_next;

    // one doubling step: lanes at or above DIST add the lane DIST below
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i >= DIST) begin : g_add
            assign sum_next[i*CW +: CW] = i_sum[i*CW +: CW] + i_sum[(i-DIST)*CW +: CW];
        end else begin : g_pass
            assign sum_next[i*CW +: CW] = i_sum[i*CW +: CW];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_vld <= 1'b0;
        end else if (en) begin
            o_vld <= i_vld;
        end
    end

    always_ff @(posedge clk) begin
        if (en) begin
            o_flag <= i_flag;
            o_data <= i_data;
            o_sum  <= sum_next;
        end
    end

endmodule

// File: rtl/lane_pack_xbar.sv
module lane_pack_xbar #(
    parameter int LANES  = 32,
    parameter int DATA_W = 16,
    parameter int CW     = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    i_vld,
    input  logic [LANES-1:0]        i_flag,
    input  logic [LANES*DATA_W-1:0] i_data,
    input  logic [LANES*CW-1:0]     i_sum,
    output logic                    o_vld,
    output logic [LANES*DATA_W-1:0] o_data,
    output logic [CW-1:0]           o_count
);

    logic [CW-1:0]           excl [LANES];
    logic [LANES*DATA_W-1:0] packed_next;

    // inclusive sum minus own flag gives the target lane
    for (genvar i = 0; i < LANES; i++) begin : g_excl
        assign excl[i] = i_sum[i*CW +: CW] - CW'(i_flag[i]);
    end

    // each output lane ORs in the single source lane that targets it
    for (genvar j = 0; j < LANES; j++) begin : g_out
        always_comb begin
            packed_next[j*DATA_W +: DATA_W] = '0;
            for (int i = j; i < LANES; i++) begin
                if (i_flag[i] && (excl[i] == CW'(j))) begin
                    packed_next[j*DATA_W +: DATA_W] = packed_next[j*DATA_W +: DATA_W]
                                                    | i_data[i*DATA_W +: DATA_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_vld <= 1'b0;
        end else if (en) begin
            o_vld <= i_vld;
        end
    end

    always_ff @(posedge clk) begin
        if (en) begin
            o_data  <= packed_next;
            o_count <= i_sum[(LANES-1)*CW +: CW];
        end
    end

endmodule

// File: rtl/lane_packer.sv
module lane_packer
    import lane_pack_pkg::*;
#(
    parameter int LANES  = int'(LP_DEF_LANES),
    parameter int DATA_W = int'(LP_DEF_DATA_W)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [LANES-1:0]            in_flags,
    input  logic [LANES*DATA_W-1:0]     in_data,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [LANES*DATA_W-1:0]     out_data,
    output logic [$clog2(LANES):0]      out_count
);

    localparam int CW     = int'(count_width(LANES));
    localparam int STAGES = $clog2(LANES);

    // index 0 is the raw input, index k+1 the output of scan step k
    logic                    st_vld  [STAGES+1];
    logic [LANES-1:0]        st_flag [STAGES+1];
    logic [LANES*DATA_W-1:0] st_data [STAGES+1];
    logic [LANES*CW-1:0]     st_sum  [STAGES+1];

    logic advance;

    // whole pipeline moves unless the output beat is held
    assign advance  = !out_valid || out_ready;
    assign in_ready = advance;

    assign st_vld[0]  = in_valid;
    assign st_flag[0] = in_flags;
    assign st_data[0] = in_data;

    // seed the scan with each lane's own flag
    for (genvar i = 0; i < LANES; i++) begin : g_seed
        assign st_sum[0][i*CW +: CW] = CW'(in_flags[i]);
    end

    for (genvar k = 0; k < STAGES; k++) begin : g_scan
        lane_pack_scan_step #(
            .LANES  (LANES),
            .DATA_W (DATA_W),
            .CW     (CW),
            .DIST   (int'(scan_dist(k)))
        ) u_step (
            .clk    (clk),
            .rst    (rst),
            .en     (advance),
            .i_vld  (st_vld[k]),
            .i_flag (st_flag[k]),
            .i_data (st_data[k]),
            .i_sum  (st_sum[k]),
            .o_vld  (st_vld[k+1]),
            .o_flag (st_flag[k+1]),
            .o_data (st_data[k+1]),
            .o_sum  (st_sum[k+1])
        );
    end

    lane_pack_xbar #(
        .LANES  (LANES),
        .DATA_W (DATA_W),
        .CW     (CW)
    ) u_xbar (
        .clk     (clk),
        .rst     (rst),
        .en      (advance),
        .i_vld   (st_vld[STAGES]),
        .i_flag  (st_flag[STAGES]),
        .i_data  (st_data[STAGES]),
        .i_sum   (st_sum[STAGES]),
        .o_vld   (out_valid),
        .o_data  (out_data),
        .o_count (out_count)
    );

endmodule

// File: rtl/lane_packer_chk.sv
module lane_packer_chk #(
    parameter int LANES  = 32,
    parameter int DATA_W = 16,
    parameter int CW     = 6
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic [LANES*DATA_W-1:0] out_data,
    input logic [CW-1:0]           out_count
);

    localparam int DEPTH = $clog2(LANES) + 1;

    int occ;

    // beats accepted but not yet delivered
    always_ff @(posedge clk) begin
        if (rst) begin
            occ <= 0;
        end else begin
            occ <= occ + ((in_valid && in_ready) ? 1 : 0) - ((out_valid && out_ready) ? 1 : 0);
        end
    end

    a_r2_count_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_count <= CW'(LANES)));

    a_r7_hold_output: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_count)));

    a_r7_stall_blocks_input: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    a_r8_ready_when_empty: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

    a_r4_occupancy_bound: assert property (@(posedge clk) disable iff (rst)
        (occ >= 0) && (occ <= DEPTH));

    a_r9_no_phantom_beat: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (occ != 0));

endmodule

bind lane_packer lane_packer_chk #(
    .LANES  (LANES),
    .DATA_W (DATA_W),
    .CW     (CW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_count (out_count)
);

// File: tb/lane_packer_bench.sv
`timescale 1ns/1ps
module lane_packer_bench;

    localparam int LANES  = 32;
    localparam int DATA_W = 16;
    localparam int CW     = $clog2(LANES) + 1;
    localparam int LAT    = $clog2(LANES) + 1;
    localparam int FW     = LANES * DATA_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [LANES-1:0]  in_flags = '0;
    logic [FW-1:0]     in_data = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [FW-1:0]     out_data;
    logic [CW-1:0]     out_count;

    always #4 clk = ~clk;

    lane_packer #(.LANES(LANES), .DATA_W(DATA_W)) u_lane_packer (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_flags(in_flags), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_count(out_count)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 0;

    logic [FW-1:0] q_data [$];
    int            q_cnt  [$];
    int            q_stamp[$];
    bit            q_lat  [$];
    string         q_tag  [$];

    bit            held_pend = 0;
    logic [FW-1:0] held_data;
    logic [CW-1:0] held_cnt;

    function automatic logic [FW-1:0] ref_pack(input logic [LANES-1:0] f,
                                               input logic [FW-1:0] d, output int cnt);
        logic [FW-1:0] r = '0;
        int j = 0;
        for (int i = 0; i < LANES; i++) begin
            if (f[i]) begin
                r[j*DATA_W +: DATA_W] = d[i*DATA_W +: DATA_W];
                j++;
            end
        end
        cnt = j;
        return r;
    endfunction

    function automatic logic [FW-1:0] rand_data();
        logic [FW-1:0] r;
        for (int i = 0; i < LANES; i++) r[i*DATA_W +: DATA_W] = DATA_W'($urandom);
        return r;
    endfunction

    function automatic logic [LANES-1:0] rand_flags(input int pct);
        logic [LANES-1:0] r;
        for (int i = 0; i < LANES; i++) r[i] = (($urandom % 100) < pct);
        return r;
    endfunction

    task automatic fail(input string req, input string what, input longint act, input longint exp);
        errors++;
        $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    endtask

    task automatic check_out();
        logic [FW-1:0] ed;
        int ec, st;
        bit lat;
        string tg;
        if (q_cnt.size() == 0) begin
            checks++;
            fail("R9", "output beat with nothing accepted", 1, 0);
            return;
        end
        ed = q_data.pop_front(); ec = q_cnt.pop_front(); st = q_stamp.pop_front();
        lat = q_lat.pop_front(); tg = q_tag.pop_front();
        checks++;
        if (out_count !== CW'(ec)) fail({tg, "/R2"}, "count", longint'(out_count), longint'(ec));
        checks++;
        for (int j = 0; j < ec; j++) begin
            if (out_data[j*DATA_W +: DATA_W] !== ed[j*DATA_W +: DATA_W]) begin
                fail(tg, $sformatf("lane %0d", j), longint'(out_data[j*DATA_W +: DATA_W]),
                     longint'(ed[j*DATA_W +: DATA_W]));
                break;
            end
        end
        if (lat) begin
            checks++;
            if (cyc - st != LAT) fail("R4", "latency", longint'(cyc - st), longint'(LAT));
        end
    endtask

    task automatic step(input bit v, input logic [LANES-1:0] f, input logic [FW-1:0] d,
                        input bit rdy, input bit lat, input string tag);
        int ec;
        logic [FW-1:0] ed;
        @(negedge clk);
        cyc++;
        in_valid = v; in_flags = f; in_data = d; out_ready = rdy;
        #1;
        if (held_pend) begin
            checks++;
            if (!out_valid || out_data !== held_data || out_count !== held_cnt)
                fail("R7", "held beat changed", longint'(out_count), longint'(held_cnt));
            held_pend = 0;
        end
        if (out_valid && !out_ready) begin
            checks++;
            if (in_ready !== 1'b0) fail("R7", "in_ready during stall", longint'(in_ready), 0);
            held_pend = 1; held_data = out_data; held_cnt = out_count;
        end
        if (out_valid && out_ready) check_out();
        if (v && in_ready) begin
            ed = ref_pack(f, d, ec);
            q_data.push_back(ed); q_cnt.push_back(ec); q_stamp.push_back(cyc);
            q_lat.push_back(lat); q_tag.push_back(tag);
        end
    endtask

    task automatic drain();
        for (int n = 0; n < 60 && q_cnt.size() != 0; n++) step(0, '0, '0, 1, 1, "R1");
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_sim();
        end
    end

    initial begin
        logic [LANES-1:0] f;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R8: reset state
        checks++;
        if (out_valid !== 1'b0) fail("R8", "out_valid after reset", longint'(out_valid), 0);
        checks++;
        if (in_ready !== 1'b1) fail("R8", "in_ready after reset", longint'(in_ready), 1);

        // directed corners, continuous ready so latency is fixed
        f = '0; f[0] = 1'b1; f[3] = 1'b1;
        step(1, f, rand_data(), 1, 1, "R3");
        step(1, '0, rand_data(), 1, 1, "R5");
        step(1, '1, rand_data(), 1, 1, "R6");
        f = '0; f[LANES-1] = 1'b1;
        step(1, f, rand_data(), 1, 1, "R1");
        f = '0; f[LANES-1] = 1'b1; f[0] = 1'b1;
        step(1, f, rand_data(), 1, 1, "R3");
        step(1, '1, rand_data(), 1, 1, "R6");
        step(1, 32'hAAAA_AAAA, rand_data(), 1, 1, "R1");
        drain();

        // random beats back to back, no backpressure
        for (int n = 0; n < 200; n++) step(1, rand_flags($urandom % 101), rand_data(), 1, 1, "R1");
        drain();

        // random valid and ready pattern
        for (int n = 0; n < 300; n++)
            step(($urandom % 4) != 0, rand_flags($urandom % 101), rand_data(),
                 ($urandom % 3) != 0, 0, "R7");
        for (int n = 0; n < 60 && q_cnt.size() != 0; n++) step(0, '0, '0, 1, 0, "R7");

        // R9: flags and data toggling with in_valid low
        for (int n = 0; n < 20; n++) step(0, rand_flags(50), rand_data(), 1, 0, "R9");
        checks++;
        if (out_valid !== 1'b0) fail("R9", "out_valid while idle", longint'(out_valid), 0);
        checks++;
        if (q_cnt.size() != 0) fail("R7", "beats not delivered", longint'(q_cnt.size()), 0);

        done = 1;
        finish_sim();
    end

endmodule